// File: doc/BRIEF.md
# Four-Function ALU with Gated Condition Flags

This block is the arithmetic/logic unit of a small 64-bit datapath. Two operands and a 4-bit function code enter. The result leaves in the same cycle: it passes through no register. Three candidate condition flags come with the result: zero, sign and overflow. The function codes cover addition, a subtraction in which the second operand is the minuend, bitwise AND and bitwise XOR. Every code outside that set is treated as a no-operation, which yields a cleared result and cleared flags.

A small sequential wrapper holds the architectural flag register. The register copies the candidate flags on a rising clock edge only while the flag-write enable is high, so surrounding control logic can choose which operations may change the flags. Reset is asserted asynchronously and active low. Its release is synchronised inside the block, so the flag register leaves its reset value two clock edges after `rst_n` rises.

Top module: `alu_flagged`

## Requirements
- R1: With function code 0, `result` equals `op_a + op_b` modulo 2^64.
- R2: With function code 1, `result` equals `op_b - op_a` modulo 2^64; `op_b` is the minuend.
- R3: With function code 2, `result` is `op_a & op_b`; with code 3 it is `op_a ^ op_b`; for both codes `cand_ovf` is 0.
- R4: For codes 0 to 3, `cand_zero` is 1 exactly when all 64 result bits are 0, and `cand_sign` equals result bit 63.
- R5: With code 0, `cand_ovf` is 1 exactly when both operands have the same bit 63 and result bit 63 differs from it.
- R6: With code 1, `cand_ovf` is 1 exactly when the operands differ in bit 63 and result bit 63 differs from bit 63 of `op_b`.
- R7: Codes 4 to 15 give `result` = 0 with `cand_zero`, `cand_sign` and `cand_ovf` all 0.
- R8: `result` and the candidate flags depend only on the present inputs and settle within the cycle, with no clock edge needed.
- R9: At a rising clock edge with `flag_we` = 1, `flag_zero`, `flag_sign` and `flag_ovf` take the candidate flag values present at that edge.
- R10: At a rising clock edge with `flag_we` = 0, the registered flags keep their values.
- R11: While reset is active, and until the first write after reset, the registered flags read zero=1, sign=0, overflow=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag register updates on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assertion, release synchronised inside |
| op_a | input | 64 | First operand (the subtrahend for subtraction) |
| op_b | input | 64 | Second operand (the minuend for subtraction) |
| func | input | 4 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR, others no-op |
| flag_we | input | 1 | Flag register write enable |
| result | output | 64 | Combinational result |
| cand_zero | output | 1 | Candidate zero flag |
| cand_sign | output | 1 | Candidate sign flag |
| cand_ovf | output | 1 | Candidate overflow flag |
| flag_zero | output | 1 | Registered zero flag |
| flag_sign | output | 1 | Registered sign flag |
| flag_ovf | output | 1 | Registered overflow flag |

## Verification
The embedded properties are checked on every clock edge. They cover the following: loading and holding of the flag register, the forced-low overflow for the logical codes, the all-clear output for undefined codes, and the agreement between the zero and sign candidates and the result. Only the bench scenarios can show the arithmetic values themselves. This applies to the ordering of the subtraction operands, the overflow corner cases at the signed extremes, a subtraction that produces zero, and the reset value before the first write. Each scenario is compared against a reference model that uses 65-bit sign-extended arithmetic.

// File: rtl/alu_fn_pkg.sv
package alu_fn_pkg;

  localparam int FUNC_W = 4;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_AND = 4'd2,
    FN_XOR = 4'd3
  } alu_fn_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic ovf;
  } alu_flags_t;

  localparam alu_flags_t FLAGS_RST = '{zero: 1'b1, sign: 1'b0, ovf: 1'b0};

endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);

  localparam int MSB = W - 1;

  logic [W-1:0] addend;

  // Subtraction is b + ~a + 1, so b stays the minuend.
  always_comb begin
    addend = sub ? ~a : a;
    sum    = b + addend + {{(W-1){1'b0}}, sub};
    ovf    = (addend[MSB] == b[MSB]) && (sum[MSB] != b[MSB]);
  end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_xor,
  output logic [W-1:0] y
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = sel_xor ? (a[i] ^ b[i]) : (a[i] & b[i]);
  end

endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval
  import alu_fn_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] res,
  input  logic         valid,
  input  logic         arith,
  input  logic         arith_ovf,
  output alu_flags_t   flags
);

  always_comb begin
    flags.zero = valid & ~(|res);
    flags.sign = valid & res[W-1];
    flags.ovf  = valid & arith & arith_ovf;
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_fn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  alu_flags_t d,
  output alu_flags_t q
);

  alu_flags_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= FLAGS_RST;
    else        q <= q_nxt;
  end

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(d)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
  import alu_fn_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [FUNC_W-1:0] func,
  input  logic              flag_we,
  output logic [DATA_W-1:0] result,
  output logic              cand_zero,
  output logic              cand_sign,
  output logic              cand_ovf,
  output logic              flag_zero,
  output logic              flag_sign,
  output logic              flag_ovf
);

  logic              rst_n_sync;
  logic              is_add, is_sub, is_and, is_xor;
  logic              is_arith, is_logic, fn_valid;
  logic [DATA_W-1:0] arith_sum, logic_y;
  logic              arith_ovf;
  alu_flags_t        cand, held;

  alu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  always_comb begin
    is_add   = (func == FN_ADD);
    is_sub   = (func == FN_SUB);
    is_and   = (func == FN_AND);
    is_xor   = (func == FN_XOR);
    is_arith = is_add | is_sub;
    is_logic = is_and | is_xor;
    fn_valid = is_arith | is_logic;
  end

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a(op_a), .b(op_b), .sub(is_sub), .sum(arith_sum), .ovf(arith_ovf)
  );

  alu_bitwise #(.W(DATA_W)) u_bitwise (
    .a(op_a), .b(op_b), .sel_xor(is_xor), .y(logic_y)
  );

  always_comb begin
    result = '0;
    if (is_arith)      result = arith_sum;
    else if (is_logic) result = logic_y;
  end

  alu_flag_eval #(.W(DATA_W)) u_flags (
    .res(result), .valid(fn_valid), .arith(is_arith),
    .arith_ovf(arith_ovf), .flags(cand)
  );

  alu_flag_reg u_flag_reg (
    .clk(clk), .rst_n(rst_n_sync), .we(flag_we), .d(cand), .q(held)
  );

  assign cand_zero = cand.zero;
  assign cand_sign = cand.sign;
  assign cand_ovf  = cand.ovf;
  assign flag_zero = held.zero;
  assign flag_sign = held.sign;
  assign flag_ovf  = held.ovf;

  p_no_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (func == FN_AND || func == FN_XOR) |-> !cand_ovf);

  p_zero_sign_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (func < 4'd4) |-> (cand_sign == result[DATA_W-1]) &&
                      (cand_zero == (result == '0)));

  p_ovf_arith_only_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cand_ovf |-> (func == FN_ADD || func == FN_SUB));

  p_nop_clear_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (func >= 4'd4) |-> (result == '0) && !cand_zero && !cand_sign && !cand_ovf);

endmodule

// File: tb/alu_flagged_bench.sv
module alu_flagged_bench;

  localparam int W = 64;

  typedef struct {
    logic [W-1:0] a, b;
    logic [3:0]   fn;
    logic         we;
    logic [W-1:0] res;
    logic         z, s, o;
    logic [2:0]   reg_after;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [3:0]   func = 4'd4;
  logic         flag_we = 1'b0;
  logic [W-1:0] result;
  logic         cand_zero, cand_sign, cand_ovf;
  logic         flag_zero, flag_sign, flag_ovf;

  int n_checks = 0;
  int n_fail   = 0;
  bit drv_done = 1'b0;
  bit started  = 1'b0;
  item_t sb_q[$];
  logic [2:0] model_reg = 3'b100;

  always #2 clk = ~clk;

  alu_flagged u_alu_flagged (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .func(func),
    .flag_we(flag_we), .result(result), .cand_zero(cand_zero),
    .cand_sign(cand_sign), .cand_ovf(cand_ovf), .flag_zero(flag_zero),
    .flag_sign(flag_sign), .flag_ovf(flag_ovf)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model built from the requirements with 65-bit signed arithmetic.
  function automatic item_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic [3:0] fn, input logic we,
                                  input logic [2:0] prev);
    item_t it;
    logic [W:0] ext;
    logic valid;
    it.a = a; it.b = b; it.fn = fn; it.we = we;
    it.o = 1'b0; valid = 1'b1;
    case (fn)
      4'd0: begin ext = {a[W-1], a} + {b[W-1], b}; it.res = ext[W-1:0]; it.o = ext[W] ^ ext[W-1]; end
      4'd1: begin ext = {b[W-1], b} - {a[W-1], a}; it.res = ext[W-1:0]; it.o = ext[W] ^ ext[W-1]; end
      4'd2: it.res = a & b;
      4'd3: it.res = a ^ b;
      default: begin it.res = '0; valid = 1'b0; end
    endcase
    it.z = valid && (it.res == '0);
    it.s = valid && it.res[W-1];
    it.reg_after = we ? {it.z, it.s, it.o} : prev;
    return it;
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [3:0] fn, input logic we);
    item_t it;
    @(negedge clk);
    op_a = a; op_b = b; func = fn; flag_we = we;
    it = model(a, b, fn, we, model_reg);
    model_reg = it.reg_after;
    sb_q.push_back(it);
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // Monitor: mid-cycle after each drive; combinational outputs need no edge (R8).
  initial begin : monitor
    item_t it;
    logic [2:0] exp_reg;
    logic prev_we;
    string rt, ot;
    exp_reg = 3'b100;
    prev_we = 1'b0;
    wait (started);
    while (!(drv_done && sb_q.size() == 0)) begin
      @(negedge clk);
      #1;
      if (sb_q.size() != 0) begin
        it = sb_q.pop_front();
        case (it.fn)
          4'd0: begin rt = "R1 R8 add result"; ot = "R5 add ovf"; end
          4'd1: begin rt = "R2 R8 sub result"; ot = "R6 sub ovf"; end
          4'd2, 4'd3: begin rt = "R3 logic result"; ot = "R3 logic ovf"; end
          default: begin rt = "R7 nop result"; ot = "R7 nop ovf"; end
        endcase
        check(result === it.res, rt, result, it.res);
        check(cand_ovf === it.o, ot, {63'd0, cand_ovf}, {63'd0, it.o});
        check({cand_zero, cand_sign} === {it.z, it.s},
              (it.fn > 4'd3) ? "R7 nop zero/sign" : "R4 zero/sign",
              {62'd0, cand_zero, cand_sign}, {62'd0, it.z, it.s});
        check({flag_zero, flag_sign, flag_ovf} === exp_reg,
              prev_we ? "R9 flag load" : "R10 flag hold",
              {61'd0, flag_zero, flag_sign, flag_ovf}, {61'd0, exp_reg});
        exp_reg = it.reg_after;
        prev_we = it.we;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  localparam logic [W-1:0] MAXP = 64'h7fff_ffff_ffff_ffff;
  localparam logic [W-1:0] MINN = 64'h8000_0000_0000_0000;
  localparam logic [W-1:0] ONES = 64'hffff_ffff_ffff_ffff;

  initial begin : main
    repeat (3) @(negedge clk);
    #1;
    // R11: reset value is held while reset is low.
    check({flag_zero, flag_sign, flag_ovf} === 3'b100, "R11 reset flags",
          {61'd0, flag_zero, flag_sign, flag_ovf}, 64'd4);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check({flag_zero, flag_sign, flag_ovf} === 3'b100, "R11 after release",
          {61'd0, flag_zero, flag_sign, flag_ovf}, 64'd4);
    started = 1'b1;
    drive(64'd5, 64'd7, 4'd0, 1'b0);          // R1 plain add, no write yet
    drive(64'd5, 64'd7, 4'd4, 1'b0);          // R11 still reset value
    drive(MAXP, 64'd1, 4'd0, 1'b1);           // R5 pos+pos overflow
    drive(MINN, MINN, 4'd0, 1'b1);            // R5 neg+neg overflow, zero result
    drive(ONES, 64'd1, 4'd0, 1'b1);           // R5 carry but no overflow
    drive(64'd3, 64'd10, 4'd1, 1'b1);         // R2 B-A = 7
    drive(64'd10, 64'd3, 4'd1, 1'b1);         // R2 negative result
    drive(64'd1, MINN, 4'd1, 1'b1);           // R6 overflow
    drive(ONES, MAXP, 4'd1, 1'b1);            // R6 overflow other direction
    drive(64'h1234, 64'h1234, 4'd1, 1'b1);    // R4 zero from subtract
    drive(ONES, 64'hf0f0, 4'd2, 1'b1);        // R3 AND
    drive(MINN, MINN, 4'd3, 1'b1);            // R3 XOR to zero
    drive(MAXP, 64'd1, 4'd0, 1'b0);           // R10 overflow not captured
    drive(MINN, ONES, 4'd3, 1'b0);            // R10 hold
    for (int f = 4; f < 16; f++) drive(ONES, MINN, f[3:0], 1'b1);  // R7
    for (int k = 0; k < 200; k++)
      drive(rnd64(), rnd64(), 4'($urandom_range(0, 5)), 1'($urandom));
    drive('0, '0, 4'd4, 1'b0);
    drv_done = 1'b1;
    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule